// File: doc/BRIEF.md
# Programmable-Target Branch Metric Unit

This block feeds the add-compare-select array of a 16-state binary trellis detector. Every trellis branch has its own noiseless target level, held in a loadable bank. The levels need not sit on integer partial-response points, so the detector can follow a trained or non-linear channel response. On each clock the block takes one signed equalizer sample. For every branch it forms the distance between that sample and the branch target. All 32 branch metrics then come out in parallel.

Each metric is the squared distance, clipped to a ceiling. When the distance magnitude exceeds a threshold, the block skips the squaring and outputs the ceiling value directly. A branch is numbered by its 4-bit source state followed by the new input bit, so one index names exactly one state transition. The same index addresses both the target bank and the metric output.

Top module: `ptbm_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, every metric is cleared to 0 and every target entry is cleared to 0.
- R2: For branch k, the metric is min((T[k] - S)^2, 121). T[k] and the sample S are 6-bit two's-complement values. The metric appears on the outputs one clock after the sample is presented.
- R3: If |T[k] - S| is greater than 11, the metric is exactly 121.
- R4: If |T[k] - S| is 11 or less, the metric equals the exact square of that magnitude. A magnitude of 0 gives 0 and a magnitude of 11 gives 121.
- R5: If `tgt_we` is high at a rising edge, entry `tgt_addr` takes the value `tgt_data`. The sample captured at that same edge still uses the old entry. Samples captured at later edges use the new entry.
- R6: If `tgt_we` is low, the values on `tgt_addr` and `tgt_data` have no effect on any target entry.
- R7: A write changes only the addressed entry. The other 31 entries keep their values.
- R8: Branch index k is {source_state[3:0], new_bit}. The metric of branch k is on `bm_flat[7*k +: 7]`, and its target is entry k.
- R9: No metric ever exceeds 121.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample | input | 6 | Signed equalizer sample, one per clock |
| tgt_we | input | 1 | Target bank write enable |
| tgt_addr | input | 5 | Branch index of the entry to write |
| tgt_data | input | 6 | Signed target level to store |
| bm_flat | output | 224 | 32 packed 7-bit metrics, branch k at bits 7k+6:7k |

## Verification
The hardest situations to reach are those where the distance magnitude sits right at the clip point (10, 11 and 12). Random levels rarely land there across all branches at once. So the bench loads chosen targets and drives samples that place several branches on either side of the threshold together. Random stimulus then covers the rest. Another hard case is a write and a sample captured on the same edge. The bench provokes it on purpose and checks that the old target still governs that sample.

// File: rtl/ptbm_pkg.sv
package ptbm_pkg;
    localparam int SMP_W_DEF   = 6;
    localparam int NBR_DEF     = 32;
    localparam int MET_W_DEF   = 7;
    localparam int CLIP_DEF    = 11;
    localparam int SAT_DEF     = 121;
endpackage

// File: rtl/ptbm_tgt_bank.sv
module ptbm_tgt_bank #(
    parameter int W     = ptbm_pkg::SMP_W_DEF,
    parameter int DEPTH = ptbm_pkg::NBR_DEF,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [W-1:0]         data,
    output logic [DEPTH*W-1:0]   bank_flat
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we && addr == AW'(i)) begin
                bank_d.ent[i] = data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_flat = bank_q.ent;
endmodule

// File: rtl/ptbm_metric_lane.sv
module ptbm_metric_lane #(
    parameter int W      = ptbm_pkg::SMP_W_DEF,
    parameter int MET_W  = ptbm_pkg::MET_W_DEF,
    parameter int CLIP   = ptbm_pkg::CLIP_DEF,
    parameter int SAT    = ptbm_pkg::SAT_DEF
) (
    input  logic [W-1:0]     smp,
    input  logic [W-1:0]     tgt,
    output logic [MET_W-1:0] bm
);
    localparam int DIFF_W = W + 1;
    localparam int SQ_IN_W = $clog2(CLIP + 1);
    localparam logic [DIFF_W-1:0] CLIP_V = DIFF_W'(CLIP);
    localparam logic [MET_W-1:0]  SAT_V  = MET_W'(SAT);

    logic [DIFF_W-1:0]  diff;
    logic [DIFF_W-1:0]  mag;
    logic [SQ_IN_W-1:0] mag_lo;
    logic [MET_W-1:0]   sq;
    logic               over;

    always_comb begin
        diff   = {tgt[W-1], tgt} - {smp[W-1], smp};
        mag    = diff[DIFF_W-1] ? (~diff + DIFF_W'(1)) : diff;
        over   = (mag > CLIP_V);
        mag_lo = mag[SQ_IN_W-1:0];
        sq     = MET_W'(mag_lo) * MET_W'(mag_lo);
        bm     = over ? SAT_V : sq;
    end
endmodule

// File: rtl/ptbm_top.sv
module ptbm_top #(
    parameter int W      = ptbm_pkg::SMP_W_DEF,
    parameter int NBR    = ptbm_pkg::NBR_DEF,
    parameter int MET_W  = ptbm_pkg::MET_W_DEF,
    parameter int CLIP   = ptbm_pkg::CLIP_DEF,
    parameter int SAT    = ptbm_pkg::SAT_DEF,
    localparam int AW    = $clog2(NBR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         sample,
    input  logic                 tgt_we,
    input  logic [AW-1:0]        tgt_addr,
    input  logic [W-1:0]         tgt_data,
    output logic [NBR*MET_W-1:0] bm_flat
);
    typedef struct packed {
        logic [NBR-1:0][MET_W-1:0] bm;
    } out_t;

    out_t st_d, st_q;

    logic [NBR*W-1:0]          tgt_flat;
    logic [NBR-1:0][MET_W-1:0] lane_bm;

    ptbm_tgt_bank #(.W(W), .DEPTH(NBR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (tgt_we),
        .addr      (tgt_addr),
        .data      (tgt_data),
        .bank_flat (tgt_flat)
    );

    for (genvar k = 0; k < NBR; k++) begin : g_lane
        ptbm_metric_lane #(.W(W), .MET_W(MET_W), .CLIP(CLIP), .SAT(SAT)) u_lane (
            .smp (sample),
            .tgt (tgt_flat[k*W +: W]),
            .bm  (lane_bm[k])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NBR; k++) begin
            st_d.bm[k] = lane_bm[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bm_flat = st_q.bm;
endmodule

// File: rtl/ptbm_checker.sv
module ptbm_checker (
    input logic         clk,
    input logic         rst_n,
    input logic [5:0]   sample,
    input logic         tgt_we,
    input logic [4:0]   tgt_addr,
    input logic [5:0]   tgt_data,
    input logic [223:0] bm_flat,
    input logic [191:0] bank_flat
);
    function automatic logic [6:0] ref_bm(logic [5:0] s, logic [5:0] t);
        int d;
        int sq;
        d  = int'($signed(t)) - int'($signed(s));
        sq = d * d;
        return (sq > 121) ? 7'd121 : 7'(sq);
    endfunction

    function automatic int abs_dist(logic [5:0] s, logic [5:0] t);
        int d;
        d = int'($signed(t)) - int'($signed(s));
        return (d < 0) ? -d : d;
    endfunction

    for (genvar k = 0; k < 32; k++) begin : g_chk
        // R9: ceiling never exceeded
        p_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
            bm_flat[k*7 +: 7] <= 7'd121);
        // R2: metric matches the clipped-square model one clock later
        p_model_r2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> bm_flat[k*7 +: 7] == ref_bm($past(sample), $past(bank_flat[k*6 +: 6])));
        // R3: large distance saturates
        p_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
            abs_dist(sample, bank_flat[k*6 +: 6]) > 11 |=> bm_flat[k*7 +: 7] == 7'd121);
        // R4: zero distance gives zero
        p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            sample == bank_flat[k*6 +: 6] |=> bm_flat[k*7 +: 7] == 7'd0);
    end

    // R5: a write lands in the addressed entry
    p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |=> bank_flat[$past(tgt_addr)*6 +: 6] == $past(tgt_data));
    // R6: no write, no change
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_we |=> $stable(bank_flat));
endmodule

bind ptbm_top ptbm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (sample),
    .tgt_we    (tgt_we),
    .tgt_addr  (tgt_addr),
    .tgt_data  (tgt_data),
    .bm_flat   (bm_flat),
    .bank_flat (tgt_flat)
);

// File: tb/test_ptbm_top.sv
module test_ptbm_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   sample = '0;
    logic         tgt_we = 1'b0;
    logic [4:0]   tgt_addr = '0;
    logic [5:0]   tgt_data = '0;
    logic [223:0] bm_flat;

    int n_chk = 0;
    int n_fail = 0;
    int mdl [32];
    int expv [32];
    bit done = 0;

    always #10 clk = ~clk;

    ptbm_top i_ptbm_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .tgt_we   (tgt_we),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .bm_flat  (bm_flat)
    );

    function automatic int exp_bm(int s, int t);
        int sq;
        sq = (t - s) * (t - s);
        return (sq > 121) ? 121 : sq;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check_lanes(string req);
        for (int k = 0; k < 32; k++) begin
            int act;
            act = int'(bm_flat[k*7 +: 7]);
            n_chk++;
            if (act != expv[k]) begin
                n_fail++;
                $display("FAIL %s lane %0d: actual %0d expected %0d", req, k, act, expv[k]);
            end
        end
    endtask

    // drive inputs, predict from the bank before the write, check after the edge
    task automatic step(int s, bit we, int addr, int dat, string req);
        sample   = s[5:0];
        tgt_we   = we;
        tgt_addr = addr[4:0];
        tgt_data = dat[5:0];
        for (int k = 0; k < 32; k++) expv[k] = exp_bm(s, mdl[k]);
        if (we) mdl[addr] = int'($signed(dat[5:0]));
        @(posedge clk);
        #5;
        tgt_we = 1'b0;
        check_lanes(req);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h1b5e_ed07));
        for (int k = 0; k < 32; k++) begin
            mdl[k] = 0;
            expv[k] = 0;
        end
        // R1: metrics cleared under reset
        repeat (3) @(posedge clk);
        #5;
        check_lanes("R1 reset metrics");
        rst_n = 1'b1;
        // R1: bank cleared, sample 5 against zero targets gives 25
        step(5, 0, 0, 0, "R1 reset targets");
        // R5/R7: load targets k-16 one entry per cycle
        for (int k = 0; k < 32; k++) step(k - 16, 1, k, k - 16, "R5 R7 load");
        // R4: zero distance on lane 16 and exact squares near it
        step(0, 0, 0, 0, "R4 zero and squares");
        // R3/R4: sample -5 puts lanes at distances 10, 11, 12 and beyond
        step(-5, 0, 0, 0, "R3 R4 threshold");
        // R3: extremes of range
        step(31, 1, 0, -32, "R3 extremes");
        step(-32, 0, 0, 0, "R3 extremes");
        // R5: write and sample on the same edge, new target only on the next sample
        step(7, 1, 3, 7, "R5 same-edge write");
        step(7, 0, 3, 0, "R5 after write");
        // R6: enable low with busy address and data
        step(-9, 0, 3, 25, "R6 ignored write");
        step(-9, 0, 12, -30, "R6 ignored write");
        // R8: branch {state 9, bit 1} = index 19
        step(0, 1, 19, 31, "R8 index 19");
        step(-32, 0, 0, 0, "R8 index 19");
        // R2/R9: random samples and targets
        for (int n = 0; n < 3000; n++) begin
            int s;
            int a;
            int d;
            bit w;
            s = int'($urandom_range(63)) - 32;
            a = int'($urandom_range(31));
            d = int'($urandom_range(63)) - 32;
            w = ($urandom_range(3) == 0);
            step(s, w, a, d, "R2 R9 random");
        end
        // R1: reset in mid-run clears bank and metrics
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        for (int k = 0; k < 32; k++) begin
            mdl[k] = 0;
            expv[k] = 0;
        end
        check_lanes("R1 mid-run reset");
        rst_n = 1'b1;
        step(-11, 0, 0, 0, "R1 targets zero after reset");
        done = 1;
        summary();
    end
endmodule